// File: doc/BRIEF.md
# Window-Decoded Configuration Access Translator

This block sits behind a CPU bus and turns loads and stores that land in a fixed 4 MB physical window into configuration-space transactions. The CPU does not first program an address register. The target is encoded in the access address itself. One high address bit, taken from a contiguous group of select lines, picks the device. Three bits below that group give the function, and the low byte gives the register. Every accepted access builds the 32-bit configuration address word again from its own address, and then moves the data.

Both sides use valid/ready requests. Upstream, `cpu_req_ready` is high only while the block is idle. Once a request is taken, ready stays low until the one-cycle response has been given. The CPU must accept `cpu_rsp_valid` in the cycle it is high, because there is no response back-pressure. Downstream, the configuration space may stall `cfg_req_ready` for any number of cycles, and the block holds the request steady meanwhile. Read data comes back on a one-cycle `cfg_rsp_valid` strobe. The CPU is treated as big-endian by default (`BIG_ENDIAN=1`), so halfword and word data are byte-reversed in both directions.

Top module: `cfg_window_xlate`

## Requirements
- R1: A request whose address bits 31:22 differ from those of `WIN_BASE` (default 0x8080_0000) is consumed but raises neither a downstream request nor a CPU response.
- R2: The device number is the index k (0..10) of the lowest set bit among address bits 11..21, with address bit 11+k selecting device k. With none of these bits set, the device number is 11. The function number is address bits 10:8. devfn is {device, function}.
- R3: The configuration word has bit 31 = 1, bits 30:24 = 0, bus field 23:16 = 0, devfn in bits 15:8, register bits 7:2 equal to address bits 7:2, and bits 1:0 = 0.
- R4: Byte enables use size code 0 = byte (0001 shifted left by address bits 1:0), 1 = halfword (0011 shifted left by the offset) and 2 = word (1111).
- R5: A halfword at an odd offset, a word at a nonzero offset, or size code 3 gets a response with `cpu_rsp_err`=1 and no downstream request.
- R6: Write data is moved to the byte lane of the offset, and unused lanes are zero. A byte is never reordered. With `BIG_ENDIAN`=1 a halfword has its two bytes swapped and a word has all four bytes reversed.
- R7: Read data is taken from the offset lane and right-justified. It is byte-swapped for halfwords and words with `BIG_ENDIAN`=1, and never for bytes. Unused upper bits are zero.
- R8: While `cfg_req_valid` is high and `cfg_req_ready` is low, the request stays asserted and its address, enables, data and direction do not change.
- R9: `cpu_req_ready` is low from acceptance until after the response. `cpu_rsp_valid` lasts exactly one cycle.
- R10: Each accepted in-window access produces exactly one response and at most one downstream request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req_valid | input | 1 | CPU request valid |
| cpu_req_ready | output | 1 | Block idle and able to take a request |
| cpu_req_addr | input | 32 | CPU physical address |
| cpu_req_write | input | 1 | 1 = store, 0 = load |
| cpu_req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| cpu_req_wdata | input | 32 | Store data, right-justified |
| cpu_rsp_valid | output | 1 | One-cycle completion strobe |
| cpu_rsp_rdata | output | 32 | Load data, right-justified |
| cpu_rsp_err | output | 1 | Misaligned or illegal size |
| cfg_req_valid | output | 1 | Configuration request valid |
| cfg_req_ready | input | 1 | Configuration space accepts request |
| cfg_req_addr | output | 32 | Configuration address word |
| cfg_req_write | output | 1 | Configuration write |
| cfg_req_be | output | 4 | Byte enables |
| cfg_req_wdata | output | 32 | Lane-placed write data |
| cfg_rsp_valid | input | 1 | Read data strobe |
| cfg_rsp_rdata | input | 32 | Read data, lane-aligned |

## Verification
The properties assume three things about the environment. The configuration space returns exactly one `cfg_rsp_valid` for each read it accepts and none for writes. The CPU raises no new request while `cpu_req_ready` is low. Each request's fields stay steady while its valid is high. The bench keeps to these rules through a single responder model and a task-per-scenario driver. The responder stalls `cfg_req_ready` a chosen number of cycles and answers reads one cycle after the handshake. The driver drops valid right after acceptance and waits for the idle state before starting the next scenario.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_RESP  = 2'd3
  } xl_state_e;
endpackage

// File: rtl/cfgx_decode.sv
module cfgx_decode
  import cfgx_pkg::*;
#(
  parameter int              ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'h8080_0000,
  parameter int              WIN_LOG2 = 22,
  parameter int              SEL_LSB  = 11,
  parameter int              SEL_CNT  = 11,
  parameter int              FUNC_W   = 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  acc_size_e         size,
  output logic              hit,
  output logic              bad,
  output logic [31:0]       word,
  output logic [3:0]        be
);
  localparam int DEV_W    = $clog2(SEL_CNT + 1);
  localparam int FUNC_LSB = SEL_LSB - FUNC_W;
  localparam int DEVFN_W  = DEV_W + FUNC_W;

  logic [DEV_W-1:0]   dev;
  logic [DEVFN_W-1:0] devfn;
  logic [1:0]         off;

  assign off = addr[1:0];
  assign hit = (addr[ADDR_W-1:WIN_LOG2] == WIN_BASE[ADDR_W-1:WIN_LOG2]);

  // lowest set select line wins; none set falls back to SEL_CNT
  always_comb begin
    dev = DEV_W'(SEL_CNT);
    for (int k = SEL_CNT - 1; k >= 0; k--) begin
      if (addr[SEL_LSB + k]) dev = DEV_W'(k);
    end
  end

  assign devfn = {dev, addr[SEL_LSB-1:FUNC_LSB]};
  assign word  = {1'b1, 7'd0, 8'd0, 8'(devfn), addr[7:2], 2'b00};

  always_comb begin
    unique case (size)
      SZ_BYTE: begin be = 4'b0001 << off; bad = 1'b0;      end
      SZ_HALF: begin be = 4'b0011 << off; bad = off[0];    end
      SZ_WORD: begin be = 4'b1111;        bad = |off;      end
      default: begin be = 4'b0000;        bad = 1'b1;      end
    endcase
  end
endmodule

// File: rtl/cfgx_lanes.sv
module cfgx_lanes
  import cfgx_pkg::*;
#(
  parameter bit BIG_ENDIAN = 1'b1
) (
  input  logic [31:0] wr_in,
  input  acc_size_e   wr_size,
  input  logic [1:0]  wr_off,
  output logic [31:0] wr_out,
  input  logic [31:0] rd_in,
  input  acc_size_e   rd_size,
  input  logic [1:0]  rd_off,
  output logic [31:0] rd_out
);
  logic [31:0] rd_sh;
  logic [15:0] wr_h, rd_h;
  logic [31:0] wr_w, rd_w;
  logic [31:0] wr_j;

  assign rd_sh = rd_in >> {rd_off, 3'b000};

  generate
    if (BIG_ENDIAN) begin : g_swap
      assign wr_h = {wr_in[7:0], wr_in[15:8]};
      assign wr_w = {wr_in[7:0], wr_in[15:8], wr_in[23:16], wr_in[31:24]};
      assign rd_h = {rd_sh[7:0], rd_sh[15:8]};
      assign rd_w = {rd_sh[7:0], rd_sh[15:8], rd_sh[23:16], rd_sh[31:24]};
    end else begin : g_pass
      assign wr_h = wr_in[15:0];
      assign wr_w = wr_in;
      assign rd_h = rd_sh[15:0];
      assign rd_w = rd_sh;
    end
  endgenerate

  always_comb begin
    unique case (wr_size)
      SZ_BYTE: wr_j = {24'd0, wr_in[7:0]};
      SZ_HALF: wr_j = {16'd0, wr_h};
      SZ_WORD: wr_j = wr_w;
      default: wr_j = 32'd0;
    endcase
    wr_out = wr_j << {wr_off, 3'b000};
  end

  always_comb begin
    unique case (rd_size)
      SZ_BYTE: rd_out = {24'd0, rd_sh[7:0]};
      SZ_HALF: rd_out = {16'd0, rd_h};
      SZ_WORD: rd_out = rd_w;
      default: rd_out = 32'd0;
    endcase
  end
endmodule

// File: rtl/cfgx_ctrl.sv
module cfgx_ctrl
  import cfgx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  acc_size_e   req_size,
  input  logic [1:0]  req_off,
  input  logic        dec_hit,
  input  logic        dec_bad,
  input  logic [31:0] dec_word,
  input  logic [3:0]  dec_be,
  input  logic [31:0] wr_steered,
  output acc_size_e   size_q,
  output logic [1:0]  off_q,
  input  logic [31:0] rd_steered,
  output logic        rsp_valid,
  output logic [31:0] rsp_rdata,
  output logic        rsp_err,
  output logic        cfg_valid,
  input  logic        cfg_ready,
  output logic [31:0] cfg_addr,
  output logic        cfg_write,
  output logic [3:0]  cfg_be,
  output logic [31:0] cfg_wdata,
  input  logic        cfg_rvalid
);
  xl_state_e   st_q;
  logic        err_q;
  logic [31:0] rdata_q;
  logic        take;

  assign req_ready = (st_q == ST_IDLE);
  assign take      = req_valid && req_ready;
  assign cfg_valid = (st_q == ST_ISSUE);
  assign rsp_valid = (st_q == ST_RESP);
  assign rsp_err   = rsp_valid && err_q;
  assign rsp_rdata = rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      err_q     <= 1'b0;
      rdata_q   <= 32'd0;
      cfg_addr  <= 32'd0;
      cfg_write <= 1'b0;
      cfg_be    <= 4'd0;
      cfg_wdata <= 32'd0;
      size_q    <= SZ_BYTE;
      off_q     <= 2'd0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (take && dec_hit) begin
            // configuration word rebuilt from this access's own address
            cfg_addr  <= dec_word;
            cfg_write <= req_write;
            cfg_be    <= dec_be;
            cfg_wdata <= wr_steered;
            size_q    <= req_size;
            off_q     <= req_off;
            err_q     <= dec_bad;
            rdata_q   <= 32'd0;
            st_q      <= dec_bad ? ST_RESP : ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (cfg_ready) st_q <= cfg_write ? ST_RESP : ST_WAIT;
        end
        ST_WAIT: begin
          if (cfg_rvalid) begin
            rdata_q <= rd_steered;
            st_q    <= ST_RESP;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cfg_window_xlate.sv
module cfg_window_xlate
  import cfgx_pkg::*;
#(
  parameter logic [31:0] WIN_BASE   = 32'h8080_0000,
  parameter int          WIN_LOG2   = 22,
  parameter int          SEL_LSB    = 11,
  parameter int          SEL_CNT    = 11,
  parameter bit          BIG_ENDIAN = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpu_req_valid,
  output logic        cpu_req_ready,
  input  logic [31:0] cpu_req_addr,
  input  logic        cpu_req_write,
  input  logic [1:0]  cpu_req_size,
  input  logic [31:0] cpu_req_wdata,
  output logic        cpu_rsp_valid,
  output logic [31:0] cpu_rsp_rdata,
  output logic        cpu_rsp_err,
  output logic        cfg_req_valid,
  input  logic        cfg_req_ready,
  output logic [31:0] cfg_req_addr,
  output logic        cfg_req_write,
  output logic [3:0]  cfg_req_be,
  output logic [31:0] cfg_req_wdata,
  input  logic        cfg_rsp_valid,
  input  logic [31:0] cfg_rsp_rdata
);
  acc_size_e   in_size, size_q;
  logic        dec_hit, dec_bad;
  logic [31:0] dec_word, wr_steered, rd_steered;
  logic [3:0]  dec_be;
  logic [1:0]  off_q;

  assign in_size = acc_size_e'(cpu_req_size);

  cfgx_decode #(
    .ADDR_W(32), .WIN_BASE(WIN_BASE), .WIN_LOG2(WIN_LOG2),
    .SEL_LSB(SEL_LSB), .SEL_CNT(SEL_CNT), .FUNC_W(3)
  ) u_dec (
    .addr(cpu_req_addr), .size(in_size),
    .hit(dec_hit), .bad(dec_bad), .word(dec_word), .be(dec_be)
  );

  cfgx_lanes #(.BIG_ENDIAN(BIG_ENDIAN)) u_lanes (
    .wr_in(cpu_req_wdata), .wr_size(in_size), .wr_off(cpu_req_addr[1:0]),
    .wr_out(wr_steered),
    .rd_in(cfg_rsp_rdata), .rd_size(size_q), .rd_off(off_q),
    .rd_out(rd_steered)
  );

  cfgx_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(cpu_req_valid), .req_ready(cpu_req_ready),
    .req_write(cpu_req_write), .req_size(in_size), .req_off(cpu_req_addr[1:0]),
    .dec_hit(dec_hit), .dec_bad(dec_bad), .dec_word(dec_word), .dec_be(dec_be),
    .wr_steered(wr_steered), .size_q(size_q), .off_q(off_q),
    .rd_steered(rd_steered),
    .rsp_valid(cpu_rsp_valid), .rsp_rdata(cpu_rsp_rdata), .rsp_err(cpu_rsp_err),
    .cfg_valid(cfg_req_valid), .cfg_ready(cfg_req_ready),
    .cfg_addr(cfg_req_addr), .cfg_write(cfg_req_write),
    .cfg_be(cfg_req_be), .cfg_wdata(cfg_req_wdata),
    .cfg_rvalid(cfg_rsp_valid)
  );
endmodule

// File: rtl/cfgx_window_chk.sv
module cfgx_window_chk #(
  parameter logic [31:0] WIN_BASE = 32'h8080_0000,
  parameter int          WIN_LOG2 = 22
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cpu_req_valid,
  input logic        cpu_req_ready,
  input logic [31:0] cpu_req_addr,
  input logic [1:0]  cpu_req_size,
  input logic        cpu_rsp_valid,
  input logic        cpu_rsp_err,
  input logic        cfg_req_valid,
  input logic        cfg_req_ready,
  input logic [31:0] cfg_req_addr,
  input logic        cfg_req_write,
  input logic [3:0]  cfg_req_be,
  input logic [31:0] cfg_req_wdata
);
  logic acc, in_win, misal;
  assign acc    = cpu_req_valid && cpu_req_ready;
  assign in_win = (cpu_req_addr[31:WIN_LOG2] == WIN_BASE[31:WIN_LOG2]);
  assign misal  = (cpu_req_size == 2'd3) ||
                  (cpu_req_size == 2'd1 && cpu_req_addr[0]) ||
                  (cpu_req_size == 2'd2 && cpu_req_addr[1:0] != 2'd0);

  // R1
  outside_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !in_win) |=> (!cfg_req_valid && !cpu_rsp_valid));

  // R2
  dev_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req_valid |-> (cfg_req_addr[15:11] <= 5'd11));

  // R3
  word_format_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req_valid |-> (cfg_req_addr[31] && cfg_req_addr[30:16] == 15'd0 &&
                       cfg_req_addr[1:0] == 2'd0));

  // R4
  be_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req_valid |-> ($countones(cfg_req_be) == 1 || cfg_req_be == 4'b0011 ||
                       cfg_req_be == 4'b1100 || cfg_req_be == 4'b1111));

  // R5
  misalign_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_win && misal) |=> (!cfg_req_valid && cpu_rsp_valid && cpu_rsp_err));

  // R8
  hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req_valid && !cfg_req_ready) |=> (cfg_req_valid && $stable(cfg_req_addr) &&
      $stable(cfg_req_be) && $stable(cfg_req_wdata) && $stable(cfg_req_write)));

  // R9
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rsp_valid |=> !cpu_rsp_valid);

  // R9
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rsp_valid || cfg_req_valid) |-> !cpu_req_ready);
endmodule

bind cfg_window_xlate cfgx_window_chk #(.WIN_BASE(WIN_BASE), .WIN_LOG2(WIN_LOG2)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
  .cpu_req_addr(cpu_req_addr), .cpu_req_size(cpu_req_size),
  .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_err(cpu_rsp_err),
  .cfg_req_valid(cfg_req_valid), .cfg_req_ready(cfg_req_ready),
  .cfg_req_addr(cfg_req_addr), .cfg_req_write(cfg_req_write),
  .cfg_req_be(cfg_req_be), .cfg_req_wdata(cfg_req_wdata)
);

// File: tb/tb_cfg_window_xlate.sv
`timescale 1ns/1ps
module tb_cfg_window_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req_valid = 1'b0;
  logic        cpu_req_ready;
  logic [31:0] cpu_req_addr = 32'd0;
  logic        cpu_req_write = 1'b0;
  logic [1:0]  cpu_req_size = 2'd0;
  logic [31:0] cpu_req_wdata = 32'd0;
  logic        cpu_rsp_valid;
  logic [31:0] cpu_rsp_rdata;
  logic        cpu_rsp_err;
  logic        cfg_req_valid;
  logic        cfg_req_ready = 1'b0;
  logic [31:0] cfg_req_addr;
  logic        cfg_req_write;
  logic [3:0]  cfg_req_be;
  logic [31:0] cfg_req_wdata;
  logic        cfg_rsp_valid = 1'b0;
  logic [31:0] cfg_rsp_rdata = 32'd0;

  always #4 clk = ~clk;

  cfg_window_xlate dut (.*);

  int vectors = 0, miscompares = 0;
  int stall_len = 0, wait_cnt = 0;
  int hs_cnt = 0, rsp_cnt = 0, hold_bad = 0;
  logic        rd_pend = 1'b0;
  logic [31:0] model_rdata = 32'h1122_3344;
  logic [31:0] hs_addr, hs_wdata, snap_addr, snap_wdata, rsp_data;
  logic [3:0]  hs_be;
  logic        hs_we, rsp_e;

  // configuration-space responder and observers, all at the falling edge
  always @(negedge clk) begin
    if (rd_pend) begin cfg_rsp_valid = 1'b1; cfg_rsp_rdata = model_rdata; rd_pend = 1'b0; end
    else begin cfg_rsp_valid = 1'b0; cfg_rsp_rdata = 32'd0; end
    if (cfg_req_valid) begin
      if (wait_cnt == 0) begin snap_addr = cfg_req_addr; snap_wdata = cfg_req_wdata; end
      else if (snap_addr != cfg_req_addr || snap_wdata != cfg_req_wdata) hold_bad++;
      if (wait_cnt >= stall_len) begin
        cfg_req_ready = 1'b1;
        hs_cnt++; hs_addr = cfg_req_addr; hs_we = cfg_req_write;
        hs_be = cfg_req_be; hs_wdata = cfg_req_wdata;
        if (!cfg_req_write) rd_pend = 1'b1;
      end else cfg_req_ready = 1'b0;
      wait_cnt++;
    end else begin
      cfg_req_ready = 1'b0; wait_cnt = 0;
    end
    if (cpu_rsp_valid) begin rsp_cnt++; rsp_data = cpu_rsp_rdata; rsp_e = cpu_rsp_err; end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(input logic [31:0] a);
    int d = 11;
    for (int k = 10; k >= 0; k--) if (a[11+k]) d = k;
    return 32'h8000_0000 | (32'(d * 8 + int'(a[10:8])) << 8) | (a & 32'h0000_00FC);
  endfunction

  function automatic logic [31:0] sw32(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  int hs0, rsp0;
  task automatic access(input logic [31:0] a, input logic we, input logic [1:0] sz,
                        input logic [31:0] wd, input int stall);
    hs0 = hs_cnt; rsp0 = rsp_cnt; stall_len = stall;
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_addr = a; cpu_req_write = we;
    cpu_req_size = sz; cpu_req_wdata = wd;
    while (!cpu_req_ready) @(negedge clk);
    @(negedge clk);
    cpu_req_valid = 1'b0;
    repeat (20) @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R9 reset ready", 32'(cpu_req_ready), 32'd1);
    chk("R9 reset rsp", 32'(cpu_rsp_valid), 32'd0);
    chk("R8 reset cfg valid", 32'(cfg_req_valid), 32'd0);
  endtask

  task automatic t_read_word;
    logic [31:0] a = 32'h8080_0000 | (1 << 13) | (1 << 17) | (5 << 8) | 32'h3C;
    model_rdata = 32'h1122_3344;
    access(a, 1'b0, 2'd2, 32'd0, 0);
    chk("R10 one request", 32'(hs_cnt - hs0), 32'd1);
    chk("R10 one response", 32'(rsp_cnt - rsp0), 32'd1);
    chk("R2 R3 word dev2", hs_addr, exp_word(a));
    chk("R3 literal", hs_addr, 32'h8000_153C);
    chk("R4 be word", 32'(hs_be), 32'hF);
    chk("R7 read word swap", rsp_data, 32'h4433_2211);
    chk("R5 no err", 32'(rsp_e), 32'd0);
  endtask

  task automatic t_dev_edges;
    logic [31:0] a = 32'h8080_0000 | (3 << 8) | 32'h10;
    access(a, 1'b0, 2'd2, 32'd0, 0);
    chk("R2 no select bit -> dev 11", hs_addr, 32'h8000_5B10);
    a = 32'h8080_0000 | (1 << 21) | 32'h04;
    access(a, 1'b0, 2'd2, 32'd0, 1);
    chk("R2 top select bit -> dev 10", hs_addr, 32'h8000_5004);
    a = 32'h8080_0000 | (1 << 11) | (1 << 21) | (7 << 8);
    access(a, 1'b0, 2'd2, 32'd0, 0);
    chk("R2 lowest wins", hs_addr, exp_word(a));
  endtask

  task automatic t_write_word_stall;
    hold_bad = 0;
    access(32'h80A0_4008 | (1 << 14), 1'b1, 2'd2, 32'hA1B2_C3D4, 4);
    chk("R6 word swap", hs_wdata, 32'hD4C3_B2A1);
    chk("R8 held during stall", 32'(hold_bad), 32'd0);
    chk("R8 single handshake", 32'(hs_cnt - hs0), 32'd1);
    chk("R10 write response", 32'(rsp_cnt - rsp0), 32'd1);
    chk("R6 write flag", 32'(hs_we), 32'd1);
  endtask

  task automatic t_sub_word;
    access(32'h8080_0802, 1'b1, 2'd1, 32'hFFFF_1234, 0);
    chk("R4 half be", 32'(hs_be), 32'hC);
    chk("R6 half swap lane2", hs_wdata, 32'h3412_0000);
    access(32'h8080_0803, 1'b1, 2'd0, 32'hFFFF_FF5A, 0);
    chk("R4 byte be", 32'(hs_be), 32'h8);
    chk("R6 byte lane3", hs_wdata, 32'h5A00_0000);
    model_rdata = 32'hAABB_CCDD;
    access(32'h8080_0802, 1'b0, 2'd1, 32'd0, 2);
    chk("R7 half read swap", rsp_data, 32'h0000_BBAA);
    access(32'h8080_0801, 1'b0, 2'd0, 32'd0, 0);
    chk("R7 byte read", rsp_data, 32'h0000_00CC);
    chk("R4 byte be lane1", 32'(hs_be), 32'h2);
  endtask

  task automatic t_misaligned;
    access(32'h8080_0802, 1'b0, 2'd2, 32'd0, 0);
    chk("R5 no request", 32'(hs_cnt - hs0), 32'd0);
    chk("R5 err response", 32'(rsp_cnt - rsp0), 32'd1);
    chk("R5 err flag", 32'(rsp_e), 32'd1);
    access(32'h8080_0801, 1'b1, 2'd1, 32'd0, 0);
    chk("R5 odd half err", 32'(rsp_e), 32'd1);
    chk("R5 odd half no request", 32'(hs_cnt - hs0), 32'd0);
    access(32'h8080_0800, 1'b1, 2'd3, 32'd0, 0);
    chk("R5 size3 err", 32'(rsp_e), 32'd1);
  endtask

  task automatic t_outside;
    access(32'h80C0_0000, 1'b1, 2'd2, 32'h1, 0);
    chk("R1 above window no request", 32'(hs_cnt - hs0), 32'd0);
    chk("R1 above window no response", 32'(rsp_cnt - rsp0), 32'd0);
    access(32'h807F_FFFC, 1'b0, 2'd2, 32'd0, 0);
    chk("R1 below window no request", 32'(hs_cnt - hs0), 32'd0);
    chk("R1 below window no response", 32'(rsp_cnt - rsp0), 32'd0);
    chk("R9 idle after ignore", 32'(cpu_req_ready), 32'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reset();
    t_read_word();
    t_dev_edges();
    t_write_word_stall();
    t_sub_word();
    t_misaligned();
    t_outside();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule